// File: doc/BRIEF.md
# Late-Write Synchronous Burst SRAM

A synthesizable behavioural model of a synchronous static RAM that never needs an idle cycle between a read and a write. Address, command and write data are all taken on the rising clock edge. The word is built from two 9-bit byte lanes, and each lane has its own write enable. A static mode input picks one of two read timings, flow-through or pipelined. The write data delay tracks that mode, so a read and a write issued back to back use the shared data bus in successive cycles without colliding.

Write data arrives after its address, so the array is updated late. A read that reaches the output register in the same edge that delivers a pending write's data to the same word returns the new bytes, merged per byte enable with the stored word. Besides single accesses, the block runs 4-beat bursts through an advance input, in linear or interleaved order. Three chip enables gate new accesses and a sleep input blocks them. An asynchronous active-low output enable can cut the read drivers at any moment. The data bus is split into `dq_i`, `dq_o` and a drive enable `dq_oe_o` for an external tri-state pad.

Top module: `lw_burst_sram`

## Requirements
- R1: A new access starts at a rising edge only if `sleep_i`=0, `adv_i`=0, `en_a_i`=1, `en_b_ni`=0 and `en_c_i`=1 all hold. It is a write if `we_i`=1 and a read otherwise. If any enable is inactive, the cycle is a deselect: no read data is shown and nothing is written.
- R2: With `pipe_mode_i`=0 (flow-through), a read captured at edge k shows its word on `dq_o` between edge k and edge k+1.
- R3: With `pipe_mode_i`=1 (pipelined), a read captured at edge k shows its word between edge k+1 and edge k+2. Between edge k and edge k+1 it shows nothing.
- R4: With `pipe_mode_i`=0, the data for a write captured at edge k is taken from `dq_i` at edge k+1.
- R5: With `pipe_mode_i`=1, the data for a write captured at edge k is taken from `dq_i` at edge k+2.
- R6: `byte_we_i` is sampled with each write address. Bit j enables lane j, which is `dq` bits [9j+8:9j]. A lane whose enable is 0 keeps its stored content.
- R7: Reads and writes may be issued at every edge in any mix, with no idle cycles. A read always returns the latest data written to its word, including data from a write that lands in the same edge the read is registered, merged per byte enable.
- R8: With `order_ilv_i`=0 (linear), `adv_i`=1 at an edge that directly follows an issued access or beat issues the next beat in the same direction, with `byte_we_i` sampled again. The low two address bits become (start + n) mod 4 for beat n, and the upper bits stay the same. After beat 3 the sequence wraps to beat 0. Chip enables and `we_i` are ignored on an advance. `adv_i`=1 with no burst in progress is a deselect.
- R9: With `order_ilv_i`=1 (interleaved), the low two address bits of beat n are start XOR n.
- R10: `sleep_i`=1 at an edge blocks both a new access and an advance, and ends any burst in progress. Writes already issued still take their data on time.
- R11: `oe_ni`=1 forces `dq_oe_o` low at once, without waiting for a clock edge. When `oe_ni` returns to 0, the same read data is driven again.
- R12: While and after reset, `dq_oe_o` is 0 and every word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pipe_mode_i | input | 1 | Static: 1 pipelined, 0 flow-through |
| order_ilv_i | input | 1 | Static: 1 interleaved burst, 0 linear |
| sleep_i | input | 1 | Blocks new accesses while high |
| en_a_i | input | 1 | Chip enable, active high |
| en_b_ni | input | 1 | Chip enable, active low |
| en_c_i | input | 1 | Chip enable, active high |
| adv_i | input | 1 | Advance burst to next beat |
| we_i | input | 1 | 1 write, 0 read on a new access |
| byte_we_i | input | LANES (2) | Per-lane write enables |
| addr_i | input | ADDR_W (6) | Word address |
| dq_i | input | LANES*LANE_W (18) | Write data from the bus |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| dq_o | output | LANES*LANE_W (18) | Read data to the bus |
| dq_oe_o | output | 1 | Bus drive enable |

## Verification
Late-write data delivery and a read of the same word can land on the same edge. In pipelined mode this happens when a read immediately follows a write to the same address, and the read's output register loads in the edge that delivers the write data. The bench sets this up with directed back-to-back write/read pairs that use partial byte enables. It also uses random streams whose addresses are confined to a few words, so such overlaps occur often. A bench model applies each write at its data edge and computes the merged word from its own memory image. The bench compares `dq_o` against that word.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

  typedef enum logic {
    ORD_LIN = 1'b0,
    ORD_ILV = 1'b1
  } burst_ord_e;

  // low address bits for beat n of a 4-beat burst
  function automatic logic [1:0] beat_lo(input logic [1:0] start,
                                         input logic [1:0] n,
                                         input burst_ord_e ord);
    return (ord == ORD_ILV) ? (start ^ n) : (start + n);
  endfunction

endpackage

// File: rtl/lw_sram_issue.sv
module lw_sram_issue
  import lw_sram_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          order_ilv_i,
  input  logic          sleep_i,
  input  logic          en_a_i,
  input  logic          en_b_ni,
  input  logic          en_c_i,
  input  logic          adv_i,
  input  logic          we_i,
  input  logic [NB-1:0] be_i,
  input  logic [AW-1:0] addr_i,
  output logic          iss_v_o,
  output logic          iss_wr_o,
  output logic [AW-1:0] iss_addr_o,
  output logic [NB-1:0] iss_be_o,
  output logic          burst_act_o
);

  logic          act_q, wr_q;
  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q, cnt_nxt;
  logic          sel, do_adv, do_new;

  always_comb begin
    sel     = en_a_i & ~en_b_ni & en_c_i;
    do_adv  = ~sleep_i & adv_i & act_q;
    do_new  = ~sleep_i & ~adv_i & sel;
    cnt_nxt = cnt_q + 2'd1;
    iss_v_o  = do_adv | do_new;
    iss_wr_o = do_adv ? wr_q : we_i;
    iss_be_o = be_i;
    if (do_adv)
      iss_addr_o = {base_q[AW-1:2], beat_lo(base_q[1:0], cnt_nxt, burst_ord_e'(order_ilv_i))};
    else
      iss_addr_o = addr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      act_q <= iss_v_o;
      if (do_new) begin
        base_q <= addr_i;
        cnt_q  <= '0;
        wr_q   <= we_i;
      end else if (do_adv) begin
        cnt_q <= cnt_nxt;
      end
    end
  end

  assign burst_act_o = act_q;

endmodule

// File: rtl/lw_sram_stage.sv
module lw_sram_stage #(
  parameter int AW  = 6,
  parameter int NB  = 2,
  parameter int STG = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   iss_v_i,
  input  logic                   iss_wr_i,
  input  logic [AW-1:0]          iss_addr_i,
  input  logic [NB-1:0]          iss_be_i,
  output logic [STG-1:0]         v_o,
  output logic [STG-1:0]         wr_o,
  output logic [STG-1:0][AW-1:0] addr_o,
  output logic [STG-1:0][NB-1:0] be_o
);

  logic [STG-1:0]         v_d, wr_d, v_q, wr_q;
  logic [STG-1:0][AW-1:0] a_d, a_q;
  logic [STG-1:0][NB-1:0] b_d, b_q;

  for (genvar g = 0; g < STG; g++) begin : g_in
    if (g == 0) begin : g_head
      assign v_d[g]  = iss_v_i;
      assign wr_d[g] = iss_wr_i;
      assign a_d[g]  = iss_addr_i;
      assign b_d[g]  = iss_be_i;
    end else begin : g_tail
      assign v_d[g]  = v_q[g-1];
      assign wr_d[g] = wr_q[g-1];
      assign a_d[g]  = a_q[g-1];
      assign b_d[g]  = b_q[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q  <= '0;
      wr_q <= '0;
      a_q  <= '0;
      b_q  <= '0;
    end else begin
      v_q  <= v_d;
      wr_q <= wr_d;
      a_q  <= a_d;
      b_q  <= b_d;
    end
  end

  assign v_o    = v_q;
  assign wr_o   = wr_q;
  assign addr_o = a_q;
  assign be_o   = b_q;

endmodule

// File: rtl/lw_sram_array.sv
module lw_sram_array #(
  parameter int AW = 6,
  parameter int NB = 2,
  parameter int BW = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [NB-1:0]    wbe_i,
  input  logic [NB*BW-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [NB*BW-1:0] rdata_o
);

  localparam int DEPTH = 1 << AW;

  for (genvar j = 0; j < NB; j++) begin : g_lane
    logic [BW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int w = 0; w < DEPTH; w++) mem_q[w] <= '0;
      end else if (we_i && wbe_i[j]) begin
        mem_q[waddr_i] <= wdata_i[j*BW +: BW];
      end
    end

    assign rdata_o[j*BW +: BW] = mem_q[raddr_i];
  end

endmodule

// File: rtl/lw_burst_sram.sv
module lw_burst_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    pipe_mode_i,
  input  logic                    order_ilv_i,
  input  logic                    sleep_i,
  input  logic                    en_a_i,
  input  logic                    en_b_ni,
  input  logic                    en_c_i,
  input  logic                    adv_i,
  input  logic                    we_i,
  input  logic [LANES-1:0]        byte_we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES*LANE_W-1:0] dq_i,
  input  logic                    oe_ni,
  output logic [LANES*LANE_W-1:0] dq_o,
  output logic                    dq_oe_o
);

  localparam int DW  = LANES * LANE_W;
  localparam int STG = 2;

  logic                       iss_v, iss_wr, burst_act;
  logic [ADDR_W-1:0]          iss_addr;
  logic [LANES-1:0]           iss_be;
  logic [STG-1:0]             stg_v, stg_wr;
  logic [STG-1:0][ADDR_W-1:0] stg_addr;
  logic [STG-1:0][LANES-1:0]  stg_be;

  lw_sram_issue #(.AW(ADDR_W), .NB(LANES)) u_issue (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .order_ilv_i (order_ilv_i),
    .sleep_i     (sleep_i),
    .en_a_i      (en_a_i),
    .en_b_ni     (en_b_ni),
    .en_c_i      (en_c_i),
    .adv_i       (adv_i),
    .we_i        (we_i),
    .be_i        (byte_we_i),
    .addr_i      (addr_i),
    .iss_v_o     (iss_v),
    .iss_wr_o    (iss_wr),
    .iss_addr_o  (iss_addr),
    .iss_be_o    (iss_be),
    .burst_act_o (burst_act)
  );

  lw_sram_stage #(.AW(ADDR_W), .NB(LANES), .STG(STG)) u_stage (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .iss_v_i    (iss_v),
    .iss_wr_i   (iss_wr),
    .iss_addr_i (iss_addr),
    .iss_be_i   (iss_be),
    .v_o        (stg_v),
    .wr_o       (stg_wr),
    .addr_o     (stg_addr),
    .be_o       (stg_be)
  );

  // write lands when its data is on the bus: one edge late (flow) or two (pipe)
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [LANES-1:0]  mem_wbe;
  logic [DW-1:0]     rd_word, fwd_word;
  logic              s1_v, s1_rd;
  logic [ADDR_W-1:0] s1_addr;

  assign s1_v    = stg_v[0];
  assign s1_rd   = stg_v[0] & ~stg_wr[0];
  assign s1_addr = stg_addr[0];

  always_comb begin
    if (pipe_mode_i) begin
      mem_we    = stg_v[1] & stg_wr[1];
      mem_waddr = stg_addr[1];
      mem_wbe   = stg_be[1];
    end else begin
      mem_we    = stg_v[0] & stg_wr[0];
      mem_waddr = stg_addr[0];
      mem_wbe   = stg_be[0];
    end
  end

  lw_sram_array #(.AW(ADDR_W), .NB(LANES), .BW(LANE_W)) u_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mem_we),
    .waddr_i (mem_waddr),
    .wbe_i   (mem_wbe),
    .wdata_i (dq_i),
    .raddr_i (s1_addr),
    .rdata_o (rd_word)
  );

  // pipelined read registers in the same edge a pending write commits
  logic fwd_hit;
  assign fwd_hit = mem_we & pipe_mode_i & (mem_waddr == s1_addr);

  for (genvar j = 0; j < LANES; j++) begin : g_fwd
    assign fwd_word[j*LANE_W +: LANE_W] = (fwd_hit && mem_wbe[j]) ?
        dq_i[j*LANE_W +: LANE_W] : rd_word[j*LANE_W +: LANE_W];
  end

  logic          out_v_q;
  logic [DW-1:0] out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_v_q <= 1'b0;
      out_q   <= '0;
    end else begin
      out_v_q <= s1_rd;
      if (s1_rd) out_q <= fwd_word;
    end
  end

  logic rd_vis;
  assign rd_vis  = pipe_mode_i ? out_v_q : s1_rd;
  assign dq_o    = pipe_mode_i ? out_q : rd_word;
  assign dq_oe_o = rd_vis & ~oe_ni;

endmodule

// File: rtl/lw_burst_sram_chk.sv
module lw_burst_sram_chk #(
  parameter int AW = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          pipe_mode_i,
  input logic          order_ilv_i,
  input logic          sleep_i,
  input logic          en_a_i,
  input logic          en_b_ni,
  input logic          en_c_i,
  input logic          adv_i,
  input logic          we_i,
  input logic          oe_ni,
  input logic          dq_oe_o,
  input logic          s1_v,
  input logic [AW-1:0] s1_addr,
  input logic          burst_act,
  input logic          mem_we,
  input logic          rd_vis
);

  logic sel, new_rd, new_wr;
  assign sel    = en_a_i & ~en_b_ni & en_c_i;
  assign new_rd = ~sleep_i & ~adv_i & sel & ~we_i;
  assign new_wr = ~sleep_i & ~adv_i & sel & we_i;

  assert_deselect_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !sel) |=> !s1_v);

  assert_flow_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pipe_mode_i && new_rd) |=> rd_vis);

  assert_pipe_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pipe_mode_i && new_rd) |=> ##1 rd_vis);

  assert_flow_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pipe_mode_i && new_wr) |=> mem_we);

  assert_pipe_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pipe_mode_i && new_wr) |=> ##1 mem_we);

  assert_linear_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst_act && adv_i && !sleep_i && !order_ilv_i) |=>
      (s1_addr[1:0] == $past(s1_addr[1:0]) + 2'd1));

  assert_sleep_block_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> !s1_v);

  always_comb begin
    if (rst_ni && oe_ni) assert_oe_off_R11: assert (!dq_oe_o);
  end

endmodule

bind lw_burst_sram lw_burst_sram_chk #(.AW(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pipe_mode_i (pipe_mode_i),
  .order_ilv_i (order_ilv_i),
  .sleep_i     (sleep_i),
  .en_a_i      (en_a_i),
  .en_b_ni     (en_b_ni),
  .en_c_i      (en_c_i),
  .adv_i       (adv_i),
  .we_i        (we_i),
  .oe_ni       (oe_ni),
  .dq_oe_o     (dq_oe_o),
  .s1_v        (s1_v),
  .s1_addr     (s1_addr),
  .burst_act   (burst_act),
  .mem_we      (mem_we),
  .rd_vis      (rd_vis)
);

// File: tb/lw_burst_sram_test.sv
module lw_burst_sram_test;
  localparam int AW = 6, NL = 2, LW = 9, DW = NL * LW, DEP = 1 << AW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, pipe, ilv, sleep, en_a, en_b_n, en_c, adv, we, oe_n;
  logic [NL-1:0] be;
  logic [AW-1:0] addr;
  logic [DW-1:0] dq_in, dq_out;
  logic dq_oe;

  lw_burst_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .pipe_mode_i(pipe), .order_ilv_i(ilv),
    .sleep_i(sleep), .en_a_i(en_a), .en_b_ni(en_b_n), .en_c_i(en_c),
    .adv_i(adv), .we_i(we), .byte_we_i(be), .addr_i(addr), .dq_i(dq_in),
    .oe_ni(oe_n), .dq_o(dq_out), .dq_oe_o(dq_oe)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  string tag = "R12";

  // bench model of the requirements
  logic [DW-1:0] m_mem [DEP];
  logic          m_v [2], m_wr [2];
  logic [AW-1:0] m_a [2];
  logic [NL-1:0] m_be [2];
  logic          m_ov, b_act, b_wr;
  logic [DW-1:0] m_od;
  logic [AW-1:0] b_base;
  logic [1:0]    b_cnt;

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old_w, logic [DW-1:0] new_w,
                                          logic [NL-1:0] en);
    logic [DW-1:0] r = old_w;
    for (int j = 0; j < NL; j++) if (en[j]) r[j*LW +: LW] = new_w[j*LW +: LW];
    return r;
  endfunction

  function automatic logic [1:0] seq_lo(logic [1:0] s, logic [1:0] n, logic il);
    return il ? (s ^ n) : (s + n);
  endfunction

  task automatic model_reset();
    for (int w = 0; w < DEP; w++) m_mem[w] = '0;
    for (int s = 0; s < 2; s++) begin m_v[s] = 0; m_wr[s] = 0; m_a[s] = '0; m_be[s] = '0; end
    m_ov = 0; m_od = '0; b_act = 0; b_wr = 0; b_base = '0; b_cnt = '0;
  endtask

  task automatic model_edge();
    logic nv, nwr; logic [AW-1:0] na; int s;
    nv = 0; nwr = 0; na = '0;
    if (!sleep && adv && b_act) begin
      b_cnt = b_cnt + 2'd1; nv = 1; nwr = b_wr;
      na = {b_base[AW-1:2], seq_lo(b_base[1:0], b_cnt, ilv)};
    end else if (!sleep && !adv && en_a && !en_b_n && en_c) begin
      nv = 1; nwr = we; na = addr; b_base = addr; b_cnt = 0; b_wr = we;
    end
    b_act = nv;
    s = pipe ? 1 : 0;
    if (m_v[s] && m_wr[s]) m_mem[m_a[s]] = merge(m_mem[m_a[s]], dq_in, m_be[s]);
    m_ov = m_v[0] && !m_wr[0];
    if (m_ov) m_od = m_mem[m_a[0]];
    m_v[1] = m_v[0]; m_wr[1] = m_wr[0]; m_a[1] = m_a[0]; m_be[1] = m_be[0];
    m_v[0] = nv; m_wr[0] = nwr; m_a[0] = na; m_be[0] = be;
  endtask

  task automatic chk(input bit ok, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h exp %0h", tag, what, act, exp);
    end
  endtask

  task automatic auto_check();
    logic vis; logic [DW-1:0] d;
    vis = pipe ? m_ov : (m_v[0] && !m_wr[0]);
    d   = pipe ? m_od : m_mem[m_a[0]];
    chk(dq_oe == (vis && !oe_n), "dq_oe_o", 32'(dq_oe), 32'(vis && !oe_n));
    if (vis && !oe_n) chk(dq_out == d, "dq_o", 32'(dq_out), 32'(d));
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst_n) model_edge();
    @(negedge clk);
    auto_check();
  endtask

  task automatic idle();
    en_a = 0; en_b_n = 1; en_c = 1; adv = 0; we = 0; sleep = 0;
  endtask

  task automatic op(input logic w, input logic [AW-1:0] a, input logic [NL-1:0] b);
    en_a = 1; en_b_n = 0; en_c = 1; adv = 0; we = w; addr = a; be = b;
  endtask

  task automatic beat(input logic [NL-1:0] b);
    adv = 1; be = b; en_a = 0;
  endtask

  task automatic drain();
    idle(); repeat (3) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout exp finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d0, d1, old_w;
    logic [AW-1:0] seq [5];
    void'($urandom(32'd20240611));
    rst_n = 0; pipe = 0; ilv = 0; oe_n = 0; dq_in = '0; addr = '0; be = '0;
    idle();
    model_reset();
    repeat (3) @(negedge clk);
    tag = "R12";
    chk(dq_oe == 1'b0, "dq_oe_o in reset", 32'(dq_oe), 0);
    rst_n = 1;
    tick();
    op(0, 6'd5, 2'b00); tick();
    chk(dq_oe == 1'b1 && dq_out == '0, "R12 zero word", 32'(dq_out), 0);

    // R4 / R2 flow-through write then read
    tag = "R4";
    d0 = 18'h2A5C3;
    op(1, 6'd3, 2'b11); tick();
    idle(); dq_in = d0; tick();
    tag = "R2";
    op(0, 6'd3, 2'b00); dq_in = '0; tick();
    chk(dq_oe && dq_out == d0, "R2 flow read", 32'(dq_out), 32'(d0));

    // R5 / R3 pipelined
    tag = "R5";
    drain(); pipe = 1; drain();
    d1 = 18'h1B7E4;
    op(1, 6'd4, 2'b11); tick();
    idle(); dq_in = 18'h3FFFF; tick();
    dq_in = d1; tick();
    tag = "R3";
    op(0, 6'd4, 2'b00); dq_in = '0; tick();
    chk(dq_oe == 1'b0, "R3 not yet", 32'(dq_oe), 0);
    idle(); tick();
    chk(dq_oe && dq_out == d1, "R3 pipe read", 32'(dq_out), 32'(d1));

    // R7 / R6 back-to-back write then read, partial lanes, pipelined
    tag = "R7";
    drain();
    old_w = m_mem[10];
    d0 = 18'h15A3C;
    op(1, 6'd10, 2'b01); tick();
    op(0, 6'd10, 2'b00); dq_in = 18'h2FFFF; tick();
    idle(); dq_in = d0; tick();
    chk(dq_out == {old_w[17:9], d0[8:0]}, "R7 forwarded merge", 32'(dq_out),
        32'({old_w[17:9], d0[8:0]}));
    tag = "R6";
    op(0, 6'd10, 2'b00); tick(); idle(); tick();
    chk(dq_out[17:9] == old_w[17:9], "R6 lane1 kept", 32'(dq_out[17:9]), 32'(old_w[17:9]));

    // flow back-to-back R W R
    tag = "R7";
    drain(); pipe = 0; drain();
    op(0, 6'd3, 2'b00); tick();
    op(1, 6'd3, 2'b10); tick();
    d1 = 18'h0F00F;
    op(0, 6'd3, 2'b00); dq_in = d1; tick();
    chk(dq_out == {d1[17:9], 9'h1C3}, "R7 flow rwr", 32'(dq_out), 32'({d1[17:9], 9'h1C3}));

    // prefill with distinct data
    tag = "R6";
    for (int a = 0; a < DEP; a++) begin
      op(1, 6'(a), 2'b11); dq_in = 18'(($urandom % 262144) ^ a); tick();
    end
    idle(); dq_in = 18'(a_rand()); tick();

    // R8 linear burst from 6, flow, with wrap
    tag = "R8";
    seq[0] = 6; seq[1] = 7; seq[2] = 4; seq[3] = 5; seq[4] = 6;
    op(0, 6'd6, 2'b00); tick();
    chk(dq_out == m_mem[seq[0]], "R8 beat0", 32'(dq_out), 32'(m_mem[seq[0]]));
    for (int n = 1; n < 5; n++) begin
      beat(2'b00); tick();
      chk(dq_oe && dq_out == m_mem[seq[n]], "R8 beat", 32'(dq_out), 32'(m_mem[seq[n]]));
    end
    idle(); tick();

    // R9 interleaved burst from 13, pipelined
    tag = "R9";
    drain(); pipe = 1; ilv = 1; drain();
    seq[0] = 13; seq[1] = 12; seq[2] = 15; seq[3] = 14;
    op(0, 6'd13, 2'b00); tick();
    for (int n = 0; n < 4; n++) begin
      if (n < 3) beat(2'b00); else idle();
      tick();
      chk(dq_oe && dq_out == m_mem[seq[n]], "R9 beat", 32'(dq_out), 32'(m_mem[seq[n]]));
    end
    drain(); pipe = 0; ilv = 0; drain();

    // R10 sleep
    tag = "R10";
    op(0, 6'd7, 2'b00); sleep = 1; tick();
    chk(dq_oe == 1'b0, "R10 read blocked", 32'(dq_oe), 0);
    old_w = m_mem[20];
    op(1, 6'd20, 2'b11); sleep = 1; tick();
    sleep = 0; idle(); dq_in = ~old_w; tick();
    op(0, 6'd20, 2'b00); tick();
    chk(dq_out == old_w, "R10 write blocked", 32'(dq_out), 32'(old_w));
    op(0, 6'd6, 2'b00); tick();
    beat(2'b00); sleep = 1; tick();
    chk(dq_oe == 1'b0, "R10 adv blocked", 32'(dq_oe), 0);
    sleep = 0; beat(2'b00); tick();
    chk(dq_oe == 1'b0, "R10 burst ended", 32'(dq_oe), 0);

    // R11 async output enable
    tag = "R11";
    op(0, 6'd3, 2'b00); tick();
    chk(dq_oe == 1'b1, "R11 on", 32'(dq_oe), 1);
    oe_n = 1; #2;
    chk(dq_oe == 1'b0, "R11 off async", 32'(dq_oe), 0);
    oe_n = 0; #2;
    chk(dq_oe && dq_out == m_mem[3], "R11 back on", 32'(dq_out), 32'(m_mem[3]));
    idle(); tick();

    // R1 each enable inactive
    tag = "R1";
    op(0, 6'd3, 2'b00); en_a = 0; tick();
    chk(dq_oe == 1'b0, "R1 en_a", 32'(dq_oe), 0);
    op(0, 6'd3, 2'b00); en_b_n = 1; tick();
    chk(dq_oe == 1'b0, "R1 en_b", 32'(dq_oe), 0);
    op(0, 6'd3, 2'b00); en_c = 0; tick();
    chk(dq_oe == 1'b0, "R1 en_c", 32'(dq_oe), 0);
    old_w = m_mem[9];
    op(1, 6'd9, 2'b11); en_c = 0; tick();
    idle(); dq_in = ~old_w; tick();
    op(0, 6'd9, 2'b00); tick();
    chk(dq_out == old_w, "R1 write ignored", 32'(dq_out), 32'(old_w));

    // random mixes, every mode and order
    tag = "R7";
    for (int cfg = 0; cfg < 4; cfg++) begin
      drain(); pipe = cfg[0]; ilv = cfg[1]; drain();
      for (int c = 0; c < 1500; c++) begin
        int r;
        r = $urandom % 16;
        if (r < 5) beat(2'($urandom));
        else op(1'($urandom), (r == 15) ? 6'($urandom) : 6'($urandom % 8), 2'($urandom));
        sleep = ($urandom % 20) == 0;
        if (($urandom % 12) == 0) en_c = 0;
        oe_n = ($urandom % 16) == 0;
        dq_in = 18'(a_rand());
        tick();
      end
      oe_n = 0;
    end
    drain();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  function automatic int unsigned a_rand();
    return $urandom % 262144;
  endfunction

endmodule